// File: doc/BRIEF.md
# Supervisory Reset Generator

This block gathers every reason a system must be held in reset and turns them into one reset sequence on two complementary outputs: an active-high reset and an active-low reset. The reasons are a power-up indication, two digital undervoltage flags (one for the main supply, one for an auxiliary monitored rail), an active-low manual reset line driven from a push-button or a controller, and a single-cycle timeout request from a watchdog. The comparators that produce the undervoltage flags and the watchdog timer itself are outside the block.

While any reason is present, reset is held. Once all reasons are gone, a release counter runs for a fixed number of clock ticks before the outputs deassert. The counter restarts from zero whenever a reason comes back before the count completes. The manual line is asynchronous. It passes through a synchronizer and a run-length filter, so short lows are ignored. The release delay is a parameter in ticks. A static configuration input multiplies it by a second parameter for systems that need a longer settling time. As a sizing example, a 200 ms nominal delay (140 to 260 ms tolerated) at a 1 kHz tick is 200 ticks.

Top module: `srg_supervisor`

## Requirements
- R1: While `pwr_up` is high, `rst_out` is 1. When `pwr_up` falls with no other cause present, `rst_out` falls at exactly the DELAY_TICKS-th rising edge after the fall.
- R2: A high `vsup_low` sampled at a rising edge makes `rst_out` 1 after that edge. When it clears, `rst_out` falls DELAY_TICKS edges later.
- R3: A high `vaux_low` sampled at a rising edge makes `rst_out` 1 after that edge.
- R4: A low on `man_rst_n` lasting fewer than MR_MIN_TICKS consecutive clock samples has no effect on `rst_out`.
- R5: A low on `man_rst_n` lasting at least MR_MIN_TICKS samples asserts reset. With the default two synchronizer stages, `rst_out` falls DELAY_TICKS+3 edges after the line returns high.
- R6: A single-cycle `wdog_trip` pulse asserts reset at the edge that samples it. `rst_out` falls DELAY_TICKS edges after that capture edge.
- R7: Any cause that appears while the release delay is running restarts the count from zero. The full delay is then measured from the moment the cause clears.
- R8: With `long_delay` = 1, the release delay is DELAY_TICKS*EXT_MULT edges instead of DELAY_TICKS.
- R9: `rst_out_n` is always the complement of `rst_out`.
- R10: A cause sampled at the same edge where the release count would complete wins. Reset stays asserted and the delay restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the release-delay tick |
| pwr_up | input | 1 | Power-up indication, active high; also the synchronous reset |
| vsup_low | input | 1 | Main supply undervoltage flag, active high |
| vaux_low | input | 1 | Auxiliary rail undervoltage flag, active high |
| man_rst_n | input | 1 | Asynchronous manual reset line, active low |
| wdog_trip | input | 1 | Watchdog timeout request, one-cycle pulse |
| long_delay | input | 1 | Static: 1 selects the extended release delay |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |

## Verification
The delicate coincidence is a watchdog pulse that lands on the same clock edge at which the release counter reaches its terminal value. In that cycle, release and re-assertion compete. The bench clears an undervoltage flag and counts DELAY_TICKS-1 edges. It then raises `wdog_trip` so that it is sampled at the very edge that would release. The check requires `rst_out` to still be 1 after that edge, and the release to come a full DELAY_TICKS edges later. The other overlap is a cause returning partway through the count. The bench provokes it with a one-cycle auxiliary flag and judges it by the measured release time.

// File: rtl/srg_pkg.sv
package srg_pkg;

    // sequencer phases
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // every reason to hold reset, one bit each
    typedef struct packed {
        logic pwr;
        logic vsup;
        logic vaux;
        logic man;
        logic wdog;
    } cause_t;

    function automatic logic cause_any(input cause_t c);
        return |c;
    endfunction

    function automatic int unsigned ticks_needed(input int unsigned base,
                                                 input int unsigned mult);
        return base * mult;
    endfunction

endpackage

// File: rtl/srg_mr_filter.sv
module srg_mr_filter #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MR_MIN_TICKS = 8
) (
    input  logic clk,
    input  logic srst,
    input  logic line_n,
    output logic man_act
);
    localparam int unsigned LW = $clog2(MR_MIN_TICKS + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(MR_MIN_TICKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [LW-1:0]          low_cnt;

    // synchronizer chain, resets to the idle (high) level
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (srst) sync_q[0] <= 1'b1;
                    else      sync_q[0] <= line_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (srst) sync_q[g] <= 1'b1;
                    else      sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    // run-length filter: MR_MIN_TICKS consecutive low samples needed
    always_ff @(posedge clk) begin
        if (srst) begin
            low_cnt <= '0;
            man_act <= 1'b0;
        end else if (lvl) begin
            low_cnt <= '0;
            man_act <= 1'b0;
        end else if (low_cnt == LOW_LAST) begin
            man_act <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R4
    mr_short_ign_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(man_act) |-> ($past(!lvl) && $past(low_cnt) == LOW_LAST));

    // R5
    mr_drop_chk: assert property (@(posedge clk) disable iff (srst)
        lvl |=> !man_act);

endmodule

// File: rtl/srg_cause_merge.sv
module srg_cause_merge
    import srg_pkg::*;
(
    input  logic   clk,
    input  logic   pwr_up,
    input  logic   vsup_low,
    input  logic   vaux_low,
    input  logic   man_act,
    input  logic   wdog_trip,
    output cause_t causes,
    output logic   any_cause
);
    always_comb begin
        causes.pwr  = pwr_up;
        causes.vsup = vsup_low;
        causes.vaux = vaux_low;
        causes.man  = man_act;
        causes.wdog = wdog_trip;
    end

    assign any_cause = cause_any(causes);

    // R6: a watchdog pulse must always reach the sequencer
    wdog_merge_chk: assert property (@(posedge clk) disable iff (pwr_up)
        wdog_trip |-> any_cause);

endmodule

// File: rtl/srg_release_seq.sv
module srg_release_seq
    import srg_pkg::*;
#(
    parameter int unsigned DELAY_TICKS = 40,
    parameter int unsigned EXT_MULT    = 4
) (
    input  logic clk,
    input  logic srst,
    input  logic any_cause,
    input  logic long_delay,
    output logic rst_q,
    output logic rst_qn
);
    localparam int unsigned MAX_TICKS = ticks_needed(DELAY_TICKS, EXT_MULT);
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(DELAY_TICKS - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(MAX_TICKS - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = long_delay ? LAST_LONG : LAST_SHORT;

    always_ff @(posedge clk) begin
        if (srst || any_cause) begin
            state  <= SEQ_HOLD;
            cnt    <= '0;
            rst_q  <= 1'b1;
            rst_qn <= 1'b0;
        end else begin
            unique case (state)
                SEQ_HOLD, SEQ_COUNT: begin
                    if (cnt == last) begin
                        state  <= SEQ_RUN;
                        cnt    <= '0;
                        rst_q  <= 1'b0;
                        rst_qn <= 1'b1;
                    end else begin
                        state <= SEQ_COUNT;
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (srst)
        cnt <= LAST_LONG);

    // R10
    release_clean_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(rst_q) |-> $past(!any_cause));

    // R2
    cause_hold_chk: assert property (@(posedge clk) disable iff (srst)
        any_cause |=> rst_q);

    // R1
    run_quiet_chk: assert property (@(posedge clk) disable iff (srst)
        (state == SEQ_RUN) |-> !rst_q);

endmodule

// File: rtl/srg_supervisor.sv
module srg_supervisor
    import srg_pkg::*;
#(
    parameter int unsigned DELAY_TICKS  = 40,
    parameter int unsigned EXT_MULT     = 4,
    parameter int unsigned MR_MIN_TICKS = 8,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic pwr_up,
    input  logic vsup_low,
    input  logic vaux_low,
    input  logic man_rst_n,
    input  logic wdog_trip,
    input  logic long_delay,
    output logic rst_out,
    output logic rst_out_n
);
    cause_t causes;
    logic   man_act;
    logic   any_cause;

    srg_mr_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MR_MIN_TICKS(MR_MIN_TICKS)
    ) u_mr (
        .clk    (clk),
        .srst   (pwr_up),
        .line_n (man_rst_n),
        .man_act(man_act)
    );

    srg_cause_merge u_merge (
        .clk      (clk),
        .pwr_up   (pwr_up),
        .vsup_low (vsup_low),
        .vaux_low (vaux_low),
        .man_act  (man_act),
        .wdog_trip(wdog_trip),
        .causes   (causes),
        .any_cause(any_cause)
    );

    srg_release_seq #(
        .DELAY_TICKS(DELAY_TICKS),
        .EXT_MULT   (EXT_MULT)
    ) u_seq (
        .clk       (clk),
        .srst      (pwr_up),
        .any_cause (any_cause),
        .long_delay(long_delay),
        .rst_q     (rst_out),
        .rst_qn    (rst_out_n)
    );

    // R9
    out_compl_chk: assert property (@(posedge clk) disable iff (pwr_up)
        rst_out != rst_out_n);

    // R3
    aux_flag_chk: assert property (@(posedge clk) disable iff (pwr_up)
        vaux_low |=> rst_out);

    // R6
    wdog_trip_chk: assert property (@(posedge clk) disable iff (pwr_up)
        wdog_trip |=> (rst_out && !rst_out_n));

    // R5
    man_path_chk: assert property (@(posedge clk) disable iff (pwr_up)
        causes.man |=> rst_out);

endmodule

// File: tb/srg_supervisor_test.sv
module srg_supervisor_test;
    localparam int unsigned D   = 40;
    localparam int unsigned M   = 4;
    localparam int unsigned MRW = 8;

    logic clk = 1'b0;
    logic pwr_up = 1'b1;
    logic vsup_low = 1'b0;
    logic vaux_low = 1'b0;
    logic man_rst_n = 1'b1;
    logic wdog_trip = 1'b0;
    logic long_delay = 1'b0;
    logic rst_out, rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    srg_supervisor #(.DELAY_TICKS(D), .EXT_MULT(M), .MR_MIN_TICKS(MRW),
                     .SYNC_STAGES(2)) uut (
        .clk(clk), .pwr_up(pwr_up), .vsup_low(vsup_low), .vaux_low(vaux_low),
        .man_rst_n(man_rst_n), .wdog_trip(wdog_trip), .long_delay(long_delay),
        .rst_out(rst_out), .rst_out_n(rst_out_n));

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pair(input string req, input logic exp_rst);
        check(req, int'(rst_out), int'(exp_rst));
        check({req, " complement"}, int'(rst_out_n), int'(!exp_rst));
    endtask

    // counts edges until rst_out drops; inputs were changed just after edge 0
    task automatic wait_release(input int limit, output int n);
        n = 0;
        while (rst_out && n < limit) begin
            tick();
            n++;
        end
    endtask

    task automatic t_powerup();
        int n;
        repeat (3) tick();
        check_pair("R1 held during power-up", 1'b1);
        pwr_up = 1'b0;
        wait_release(4 * D * M, n);
        check("R1 release delay", n, D);
        check_pair("R9 released state", 1'b0);
    endtask

    task automatic t_supply();
        int n;
        vsup_low = 1'b1;
        tick();
        check_pair("R2 supply flag asserts", 1'b1);
        tick();
        vsup_low = 1'b0;
        wait_release(4 * D * M, n);
        check("R2 release delay", n, D);
    endtask

    task automatic t_aux_restart();
        int n;
        int held;
        vaux_low = 1'b1;
        tick();
        check_pair("R3 aux flag asserts", 1'b1);
        vaux_low = 1'b0;
        held = 0;
        repeat (15) begin
            tick();
            if (rst_out) held++;
        end
        vaux_low = 1'b1;
        tick();
        if (rst_out) held++;
        vaux_low = 1'b0;
        check("R7 held through restart", held, 16);
        wait_release(4 * D * M, n);
        check("R7 full delay after restart", n, D);
    endtask

    task automatic t_manual_short();
        int seen;
        man_rst_n = 1'b0;
        repeat (MRW - 1) tick();
        man_rst_n = 1'b1;
        seen = 0;
        repeat (MRW + 6) begin
            tick();
            if (rst_out) seen++;
        end
        check("R4 short manual low ignored", seen, 0);
    endtask

    task automatic t_manual_long();
        int n;
        int seen;
        man_rst_n = 1'b0;
        seen = 0;
        repeat (MRW + 4) begin
            tick();
            if (rst_out) seen = 1;
        end
        check("R5 manual low asserts", seen, 1);
        man_rst_n = 1'b1;
        wait_release(4 * D * M, n);
        check("R5 release after manual", n, D + 3);
    endtask

    task automatic t_wdog();
        int n;
        wdog_trip = 1'b1;
        tick();
        wdog_trip = 1'b0;
        check_pair("R6 watchdog pulse captured", 1'b1);
        wait_release(4 * D * M, n);
        check("R6 release after watchdog", n, D);
    endtask

    task automatic t_coincide();
        int n;
        vsup_low = 1'b1;
        tick();
        vsup_low = 1'b0;
        repeat (D - 1) tick();
        check_pair("R10 still held before terminal edge", 1'b1);
        wdog_trip = 1'b1;
        tick();
        wdog_trip = 1'b0;
        check_pair("R10 watchdog wins at terminal edge", 1'b1);
        wait_release(4 * D * M, n);
        check("R10 delay restarted", n, D);
    endtask

    task automatic t_extended();
        int n;
        long_delay = 1'b1;
        vsup_low = 1'b1;
        tick();
        vsup_low = 1'b0;
        wait_release(4 * D * M, n);
        check("R8 extended delay", n, D * M);
        long_delay = 1'b0;
        vaux_low = 1'b1;
        tick();
        vaux_low = 1'b0;
        wait_release(4 * D * M, n);
        check("R8 short delay restored", n, D);
    endtask

    initial begin
        t_powerup();
        t_supply();
        t_aux_restart();
        t_manual_short();
        t_manual_long();
        t_wdog();
        t_coincide();
        t_extended();
        repeat (2) tick();
        check_pair("R9 final idle", 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule